// File: doc/BRIEF.md
# Serial CRC-16 Block Checksum Unit

This unit computes a 16-bit cyclic redundancy checksum over the data bits of one block on a card data link. It takes one bit per clock, on clocks where the bit strobe is high. The divisor polynomial is x^16 + x^12 + x^5 + 1. The first bit transmitted is the highest-order term of the message, so bits go into the unit in the order they travel on the wire. Framing bits (start, end) are never presented to it. A block-start pulse clears the register before each block.

When sending, the controller first feeds the block's data bits. It then raises the emit select and strobes sixteen more times. On each of those strobes the checksum appears on the serial output, most significant bit first, while the register empties. When receiving, the data bits and then the sixteen received checksum bits are all fed as ordinary data. The match output is high when the register has returned to zero. When the link runs in stream mode rather than block mode, the unit is bypassed: it holds its state, ignores every input and drives both of its flag outputs low.

Top module: `crc16_serial`

## Requirements
- R1: While reset (rst_n low) is held, crc_q reads all zeros.
- R2: With stream_mode low, a blk_start high at a clock edge loads crc_q with zero, whatever bit_vld, bit_in and emit_crc are.
- R3: With stream_mode and blk_start low, and bit_vld high and emit_crc low, one edge applies the following update. Let f = bit_in XOR crc_q[15]. The register shifts left by one, and f is XORed into bits 0, 5 and 12. Feeding the ASCII bytes "123456789" most significant bit first from zero yields 16'h31C3.
- R4: With stream_mode and blk_start low, an edge with bit_vld low leaves crc_q unchanged.
- R5: With stream_mode low and emit_crc high, crc_bit_out equals crc_q[15] in the same cycle. If bit_vld is also high (and blk_start low), the edge shifts crc_q left with a zero entering bit 0. Sixteen such strobes therefore emit the checksum most significant bit first and leave crc_q at zero.
- R6: crc_bit_out is 0 whenever emit_crc is low.
- R7: While stream_mode is high, crc_q keeps its value at every edge regardless of blk_start, bit_vld, bit_in and emit_crc, and crc_bit_out and crc_ok are both 0.
- R8: crc_ok is 1 exactly when stream_mode is low and crc_q is zero. A received block whose data bits are followed by its own sixteen checksum bits, all fed with emit_crc low, ends with crc_ok high.
- R9: A block made only of zero data bits leaves crc_q at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| blk_start | input | 1 | Clears the checksum register for a new block |
| bit_vld | input | 1 | Strobe: consume one bit (data or emit) this clock |
| bit_in | input | 1 | Serial data bit, first-transmitted first |
| emit_crc | input | 1 | Selects the shift-out phase instead of data accumulation |
| stream_mode | input | 1 | Stream-mode link: the unit is bypassed |
| crc_q | output | 16 | Current checksum register |
| crc_bit_out | output | 1 | Serial checksum bit during the shift-out phase |
| crc_ok | output | 1 | Register is zero (receive match) |

## Verification
The bench targets random block lengths from one bit upward, because an error in the bit order or in a feedback tap only shows on some lengths and patterns. It also uses a fixed ASCII vector with a known result, which exposes a reversed or reflected polynomial. It also runs an all-zero block, which a design with a nonzero preset would turn into a nonzero checksum.

Each transmitted checksum is fed back as received data. If the shift-out phase were out of order or inverted, crc_ok would stay low on that loopback. Stream-mode stretches are driven with start pulses and strobes active, to catch a bypass that still clears or updates the register or leaks a serial bit. Start and strobe are also asserted together, to catch a clear that loses priority to the update.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

   // Register operation chosen each clock by the control decode.
   typedef enum logic [1:0] {
      CRC_OP_HOLD  = 2'd0,
      CRC_OP_CLEAR = 2'd1,
      CRC_OP_DATA  = 2'd2,
      CRC_OP_EMIT  = 2'd3
   } crc_op_e;

   // Divisor x^16 + x^12 + x^5 + 1 without its implicit top term.
   localparam logic [15:0] CRC16_CCITT_TAPS = 16'h1021;

endpackage

// File: rtl/crc16_step.sv
// One bit of polynomial division. The variant is picked by STEP_IMPL.
module crc16_step #(
   parameter int               CRC_W     = 16,
   parameter logic [CRC_W-1:0] POLY      = 16'h1021,
   parameter int               STEP_IMPL = 0
) (
   input  logic [CRC_W-1:0] cur,
   input  logic             din,
   output logic [CRC_W-1:0] nxt
);

   logic fb;
   assign fb = din ^ cur[CRC_W-1];

   generate
      if (STEP_IMPL == 0) begin : g_per_tap
         // Explicit tap per bit position.
         assign nxt[0] = fb & POLY[0];
         for (genvar i = 1; i < CRC_W; i++) begin : g_bit
            assign nxt[i] = cur[i-1] ^ (fb & POLY[i]);
         end
      end else begin : g_mask
         // Whole-word shift and masked XOR.
         assign nxt = {cur[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & POLY);
      end
   endgenerate

endmodule

// File: rtl/crc16_ctl.sv
// Decodes the strobes into a register operation.
module crc16_ctl
   import crc16_pkg::*;
(
   input  logic    blk_start,
   input  logic    bit_vld,
   input  logic    emit_crc,
   input  logic    stream_mode,
   output crc_op_e op,
   output logic    out_en
);

   always_comb begin
      if (stream_mode)       op = CRC_OP_HOLD;
      else if (blk_start)    op = CRC_OP_CLEAR;
      else if (!bit_vld)     op = CRC_OP_HOLD;
      else if (emit_crc)     op = CRC_OP_EMIT;
      else                   op = CRC_OP_DATA;
   end

   assign out_en = emit_crc & ~stream_mode;

endmodule

// File: rtl/crc16_reg.sv
// Checksum state register.
module crc16_reg
   import crc16_pkg::*;
#(
   parameter int CRC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  crc_op_e          op,
   input  logic [CRC_W-1:0] nxt,
   output logic [CRC_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         case (op)
            CRC_OP_CLEAR: q <= '0;
            CRC_OP_DATA,
            CRC_OP_EMIT:  q <= nxt;
            default:      q <= q;
         endcase
      end
   end

   // R4
   hold_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == CRC_OP_HOLD) |=> $stable(q));

endmodule

// File: rtl/crc16_serial.sv
module crc16_serial
   import crc16_pkg::*;
#(
   parameter int               CRC_W     = 16,
   parameter logic [CRC_W-1:0] POLY      = CRC16_CCITT_TAPS,
   parameter int               STEP_IMPL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             blk_start,
   input  logic             bit_vld,
   input  logic             bit_in,
   input  logic             emit_crc,
   input  logic             stream_mode,
   output logic [CRC_W-1:0] crc_q,
   output logic             crc_bit_out,
   output logic             crc_ok
);

   localparam int MSB = CRC_W - 1;

   generate
      if (CRC_W < 2) begin : g_bad_width
         $error("crc16_serial: CRC_W must be at least 2");
      end
      if (POLY[0] != 1'b1) begin : g_bad_poly
         $error("crc16_serial: POLY must have its constant term set");
      end
      if (STEP_IMPL != 0 && STEP_IMPL != 1) begin : g_bad_impl
         $error("crc16_serial: STEP_IMPL must be 0 or 1");
      end
   endgenerate

   crc_op_e          op;
   logic             out_en;
   logic             step_din;
   logic [CRC_W-1:0] step_nxt;

   crc16_ctl u_ctl (
      .blk_start  (blk_start),
      .bit_vld    (bit_vld),
      .emit_crc   (emit_crc),
      .stream_mode(stream_mode),
      .op         (op),
      .out_en     (out_en)
   );

   // During shift-out the feedback is forced to zero by feeding the MSB
   // back, so the same divider step performs a plain left shift.
   assign step_din = (op == CRC_OP_EMIT) ? crc_q[MSB] : bit_in;

   crc16_step #(.CRC_W(CRC_W), .POLY(POLY), .STEP_IMPL(STEP_IMPL)) u_step (
      .cur(crc_q),
      .din(step_din),
      .nxt(step_nxt)
   );

   crc16_reg #(.CRC_W(CRC_W)) u_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .op   (op),
      .nxt  (step_nxt),
      .q    (crc_q)
   );

   assign crc_bit_out = out_en & crc_q[MSB];
   assign crc_ok      = ~stream_mode & ~(|crc_q);

   // R2
   clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stream_mode && blk_start) |=> (crc_q == '0));

   // R3
   data_feedback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stream_mode && !blk_start && bit_vld && !emit_crc)
      |=> (crc_q[0] == $past(bit_in ^ crc_q[MSB])));

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stream_mode && !blk_start && !bit_vld) |=> $stable(crc_q));

   // R5
   emit_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stream_mode && !blk_start && bit_vld && emit_crc)
      |=> (crc_q == {$past(crc_q[MSB-1:0]), 1'b0}));

   // R6
   quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !emit_crc |-> !crc_bit_out);

   // R7
   bypass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stream_mode |=> $stable(crc_q));

   // R7
   bypass_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stream_mode |-> (!crc_bit_out && !crc_ok));

endmodule

// File: tb/tb_crc16_serial.sv
`timescale 1ns/1ps
module tb_crc16_serial;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        blk_start = 1'b0, bit_vld = 1'b0, bit_in = 1'b0;
   logic        emit_crc = 1'b0, stream_mode = 1'b0;
   logic [15:0] crc_q;
   logic        crc_bit_out, crc_ok;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   logic [15:0] model = 16'h0;
   logic        last_out;

   always #2 clk = ~clk;   // 250 MHz

   crc16_serial dut (
      .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .bit_vld(bit_vld),
      .bit_in(bit_in), .emit_crc(emit_crc), .stream_mode(stream_mode),
      .crc_q(crc_q), .crc_bit_out(crc_bit_out), .crc_ok(crc_ok)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference: long division by 0x11021, one message bit at a time.
   function automatic logic [15:0] ref_bit(input logic [15:0] r, input logic b);
      int t;
      t = ({16'h0, r} << 1) | 0;
      if (b ^ r[15]) t = t ^ 32'h11021;
      return t[15:0];
   endfunction

   // One clock of stimulus with comparison before and after the edge.
   task automatic cyc(input logic st, input logic v, input logic b,
                      input logic em, input logic sm);
      logic exp_out;
      @(negedge clk);
      blk_start = st; bit_vld = v; bit_in = b; emit_crc = em; stream_mode = sm;
      #1;
      exp_out = (!sm && em) ? model[15] : 1'b0;
      check(crc_bit_out === exp_out, (sm ? "R7 serial out" : (em ? "R5 serial out" : "R6 serial out")),
            crc_bit_out, exp_out);
      check(crc_ok === (!sm && model == 16'h0), (sm ? "R7 match flag" : "R8 match flag"),
            crc_ok, (!sm && model == 16'h0));
      last_out = crc_bit_out;
      if (!sm) begin
         if (st)            model = 16'h0;
         else if (v && em)  model = {model[14:0], 1'b0};
         else if (v)        model = ref_bit(model, b);
      end
      @(posedge clk); #1;
      check(crc_q === model, (sm ? "R7 register hold" : (st ? "R2 clear" : (v ? "R3 update" : "R4 idle hold"))),
            crc_q, model);
   endtask

   task automatic run_tx_rx(input int len);
      logic [15:0] sent;
      logic [15:0] ckq;
      logic bits [$];
      cyc(1, 0, 0, 0, 0);
      for (int i = 0; i < len; i++) begin
         bits.push_back(1'($urandom));
         cyc(0, 1, bits[i], 0, 0);
         if ($urandom_range(3) == 0) cyc(0, 0, 1'($urandom), 0, 0);  // R4 gap
      end
      ckq = model;
      for (int i = 0; i < 16; i++) begin
         cyc(0, 1, 1'($urandom), 1, 0);
         sent[15-i] = last_out;
      end
      check(sent === ckq, "R5 emitted checksum", sent, ckq);
      check(crc_q === 16'h0, "R5 empty after emit", crc_q, 0);
      // Receive side: data then the received checksum, all as data.
      cyc(1, 0, 0, 0, 0);
      foreach (bits[i]) cyc(0, 1, bits[i], 0, 0);
      for (int i = 15; i >= 0; i--) cyc(0, 1, sent[i], 0, 0);
      #0;
      check(crc_ok === 1'b1, "R8 receive match", crc_ok, 1);
   endtask

   initial begin
      string s = "123456789";
      logic [15:0] held;
      repeat (3) @(posedge clk);
      #1;
      check(crc_q === 16'h0, "R1 reset value", crc_q, 0);
      @(negedge clk); rst_n = 1'b1;

      // R3 known vector
      cyc(1, 0, 0, 0, 0);
      for (int c = 0; c < s.len(); c++)
         for (int k = 7; k >= 0; k--) cyc(0, 1, s[c][k], 0, 0);
      check(crc_q === 16'h31C3, "R3 ascii vector", crc_q, 16'h31C3);

      // R7 stream-mode bypass with active strobes
      held = crc_q;
      for (int i = 0; i < 40; i++)
         cyc(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1);
      check(crc_q === held, "R7 bypass kept value", crc_q, held);

      // R2 start wins over a simultaneous strobe
      cyc(1, 1, 1, 0, 0);
      check(crc_q === 16'h0, "R2 start priority", crc_q, 0);

      // R9 all-zero block
      cyc(1, 0, 0, 0, 0);
      for (int i = 0; i < 64; i++) cyc(0, 1, 0, 0, 0);
      check(crc_q === 16'h0, "R9 zero block", crc_q, 0);

      // Random blocks, transmit then loopback receive
      for (int n = 0; n < 60; n++) run_tx_rx(1 + $urandom_range(80));
      run_tx_rx(1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired act=%h exp=%h", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule